// File: doc/BRIEF.md
# NOR Flash Command Interface Emulator

This block is a synthesizable device-side model of a small NOR flash array with 16-bit words. Each clock cycle a host either writes or reads one word on a simple synchronous bus. Read data comes back one cycle later from a register. After reset the array reads like a ROM that is filled with all ones. Data and sector contents change only through unlock command sequences written to fixed word addresses.

A word-program or sector-erase operation runs internally for a number of cycles set by parameters. While it runs, reads return a status word instead of array contents:

- a data-polling bit (bit 7);
- an any-address toggle (bit 6);
- a failure flag (bit 5);
- an erase-running flag (bit 3);
- a toggle that moves only inside the sectors chosen for erase (bit 2).

An active-high `ready` output falls while the device is busy. An identification mode returns a manufacturer code and a device code.

Top module: `nor_cmd_emu`

## Requirements
- R1: After reset, every word reads 16'hFFFF and `ready` is 1.
- R2: The writes 8'hAA to 11'h555, 8'h55 to 11'h2AA and 8'h90 to 11'h555 enter identification mode. In this mode, word offset 0 reads MFR_ID, offset 1 reads DEV_ID and other offsets read 0. Writes other than 8'hF0 are ignored, and a write of 8'hF0 returns to array reads.
- R3: The writes 8'hAA to 11'h555, 8'h55 to 11'h2AA and 8'hA0 to 11'h555, followed by a data write to a word, store that data at the word. Programming may only clear bits.
- R4: While a program runs, bit 7 of any read is the complement of bit 7 of the written data. Once the program ends, reads return the stored data.
- R5: The writes 8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55 (to 11'h555, 11'h2AA, 11'h555, 11'h555, 11'h2AA), then 8'h30 to any word of a sector, erase that sector. Every word of each chosen sector becomes 16'hFFFF and other sectors are unchanged. The sector number is the top SECT_W bits of the word index. During the erase, bit 7 reads 0 inside a chosen sector.
- R6: While busy, bit 6 inverts on every read at any address. After the operation ends, repeated reads are stable.
- R7: During an erase, bit 2 inverts between successive reads only when the address lies in a chosen sector. Reads of other sectors leave it unchanged.
- R8: A program data write that would raise a 0 bit to 1 leaves the array unchanged and sets bit 5 of reads to 1 with `ready` at 0. This state holds through any writes except 8'hF0, which returns to array reads.
- R9: During the accept window after an 8'h30 write, bit 3 reads 0, and further 8'h30 writes add sectors and restart the window. After the window expires, bit 3 reads 1 and all writes are ignored until the erase ends.
- R10: `ready` is 0 for exactly PROG_CYC cycles after a program data write. For an erase it is 0 for ERASE_WIN cycles after the last 8'h30, plus ERASE_CYC cycles per chosen sector. The device then returns to array reads by itself.
- R11: A wrong address or data value in any cycle of a command sequence drops back to array reads, and no operation starts.
- R12: Command matching uses only bits 7:0 of the write data, so upper data bits do not affect command decoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data or command byte |
| rdata | output | DATA_W | Registered read data, valid the cycle after `rd_en` |
| ready | output | 1 | 1 when idle, 0 while an operation runs or has failed |

## Verification
A wrong command-decoder state shows up on the next read. That read returns array data where status was due, or the reverse, and a missed or spurious program is seen when the word is read back. A counter that is off by one shows up as a `ready` low interval of the wrong length, which the bench measures to the cycle. A wrong sector-selection mask shows up as bit 2 toggling in the wrong sector, or as the wrong sectors reading all ones after the erase.

// File: rtl/nor_emu_pkg.sv
package nor_emu_pkg;

    typedef enum logic [3:0] {
        S_READ,
        S_UNL1,
        S_UNL2,
        S_PROG_WAIT,
        S_AUTOSEL,
        S_ERA_SET,
        S_ERA_UNL1,
        S_ERA_UNL2,
        S_PROG_BUSY,
        S_ERA_WIN,
        S_ERA_BUSY,
        S_FAIL
    } nor_state_e;

    localparam logic [7:0]  C_KEY1   = 8'hAA;
    localparam logic [7:0]  C_KEY2   = 8'h55;
    localparam logic [7:0]  C_PROG   = 8'hA0;
    localparam logic [7:0]  C_IDENT  = 8'h90;
    localparam logic [7:0]  C_ERASE  = 8'h80;
    localparam logic [7:0]  C_SECT   = 8'h30;
    localparam logic [7:0]  C_RESET  = 8'hF0;
    localparam logic [10:0] A_KEY1   = 11'h555;
    localparam logic [10:0] A_KEY2   = 11'h2AA;

endpackage

// File: rtl/nor_emu_array.sv
module nor_emu_array #(
    parameter int ARR_W  = 6,
    parameter int SECT_W = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ARR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word,
    input  logic              prog_en,
    input  logic [ARR_W-1:0]  prog_idx,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_en,
    input  logic [SECT_W-1:0] erase_sect
);
    localparam int DEPTH    = 1 << ARR_W;
    localparam int SWORDS_W = ARR_W - SECT_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        localparam logic [ARR_W-1:0] IDX = ARR_W'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '1;
            end else if (erase_en && IDX[ARR_W-1 -: SECT_W] == erase_sect) begin
                mem_q[g] <= '1;
            end else if (prog_en && IDX == prog_idx) begin
                mem_q[g] <= mem_q[g] & prog_data;
            end
        end
    end

    assign rd_word = mem_q[rd_idx];

    // R5: first word of an erased sector is all ones afterwards
    p_erase_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> mem_q[{$past(erase_sect), {SWORDS_W{1'b0}}}] == '1);

    // R3: the controller never asks to raise a bit, so the word holds the data exactly
    p_prog_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && !erase_en) |=> mem_q[$past(prog_idx)] == $past(prog_data));

endmodule

// File: rtl/nor_emu_status.sv
module nor_emu_status #(
    parameter int DATA_W = 16
) (
    input  logic              prog_act,
    input  logic              erase_run,
    input  logic              fail,
    input  logic              pbit7,
    input  logic              tog,
    input  logic              tog2,
    output logic [DATA_W-1:0] status
);
    always_comb begin
        status    = '0;
        status[7] = prog_act ? ~pbit7 : 1'b0;
        status[6] = tog;
        status[5] = fail;
        status[3] = erase_run;
        status[2] = tog2;
    end
endmodule

// File: rtl/nor_cmd_emu.sv
module nor_cmd_emu
    import nor_emu_pkg::*;
#(
    parameter int          ADDR_W    = 11,
    parameter int          DATA_W    = 16,
    parameter int          ARR_W     = 6,
    parameter int          SECT_W    = 2,
    parameter int          PROG_CYC  = 5,
    parameter int          ERASE_WIN = 4,
    parameter int          ERASE_CYC = 12,
    parameter logic [15:0] MFR_ID    = 16'h00C2,
    parameter logic [15:0] DEV_ID    = 16'h22A7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready
);
    localparam int NSECT = 1 << SECT_W;
    localparam int MAXC  = (PROG_CYC > ERASE_WIN)
                         ? ((PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC)
                         : ((ERASE_WIN > ERASE_CYC) ? ERASE_WIN : ERASE_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        nor_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ARR_W-1:0]  pidx;
        logic [DATA_W-1:0] pdata;
        logic [NSECT-1:0]  sel;
        logic [NSECT-1:0]  pend;
        logic              tog;
        logic              tog2;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t q, d;

    logic [ARR_W-1:0]  idx_d;
    logic [SECT_W-1:0] sect_d;
    logic [7:0]        cmd_d;
    logic [10:0]       cadr_d;
    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] stat_word;
    logic [SECT_W-1:0] low_sect;
    logic [NSECT-1:0]  pend_left;
    logic              busy_d, erase_act_d;
    logic              prog_en, erase_en;

    assign idx_d       = addr[ARR_W-1:0];
    assign sect_d      = idx_d[ARR_W-1 -: SECT_W];
    assign cmd_d       = wdata[7:0];
    assign cadr_d      = addr[10:0];
    assign busy_d      = q.st inside {S_PROG_BUSY, S_ERA_WIN, S_ERA_BUSY, S_FAIL};
    assign erase_act_d = q.st inside {S_ERA_WIN, S_ERA_BUSY};

    always_comb begin
        low_sect = '0;
        for (int s = NSECT - 1; s >= 0; s--) begin
            if (q.pend[s]) low_sect = SECT_W'(s);
        end
    end
    assign pend_left = q.pend & ~(NSECT'(1) << low_sect);

    nor_emu_array #(.ARR_W(ARR_W), .SECT_W(SECT_W), .DATA_W(DATA_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (idx_d),
        .rd_word   (arr_word),
        .prog_en   (prog_en),
        .prog_idx  (q.pidx),
        .prog_data (q.pdata),
        .erase_en  (erase_en),
        .erase_sect(low_sect)
    );

    nor_emu_status #(.DATA_W(DATA_W)) u_status (
        .prog_act (q.st inside {S_PROG_BUSY, S_FAIL}),
        .erase_run(q.st == S_ERA_BUSY),
        .fail     (q.st == S_FAIL),
        .pbit7    (q.pdata[7]),
        .tog      (q.tog),
        .tog2     (q.tog2),
        .status   (stat_word)
    );

    always_comb begin
        d        = q;
        prog_en  = 1'b0;
        erase_en = 1'b0;

        if (rd_en) begin
            if (busy_d) begin
                d.rdata = stat_word;
                d.tog   = ~q.tog;
                if (erase_act_d && q.sel[sect_d]) d.tog2 = ~q.tog2;
            end else if (q.st == S_AUTOSEL) begin
                if (idx_d == '0)                d.rdata = DATA_W'(MFR_ID);
                else if (idx_d == ARR_W'(1))    d.rdata = DATA_W'(DEV_ID);
                else                            d.rdata = '0;
            end else begin
                d.rdata = arr_word;
            end
        end

        unique case (q.st)
            S_READ: if (wr_en && cadr_d == A_KEY1 && cmd_d == C_KEY1) d.st = S_UNL1;
            S_UNL1: if (wr_en) d.st = (cadr_d == A_KEY2 && cmd_d == C_KEY2) ? S_UNL2 : S_READ;
            S_UNL2: if (wr_en) begin
                d.st = S_READ;
                if (cadr_d == A_KEY1) begin
                    if (cmd_d == C_PROG)       d.st = S_PROG_WAIT;
                    else if (cmd_d == C_IDENT) d.st = S_AUTOSEL;
                    else if (cmd_d == C_ERASE) d.st = S_ERA_SET;
                end
            end
            S_PROG_WAIT: if (wr_en) begin
                d.pidx  = idx_d;
                d.pdata = wdata;
                if (|(wdata & ~arr_word)) begin
                    d.st = S_FAIL;
                end else begin
                    d.st  = S_PROG_BUSY;
                    d.cnt = CNT_W'(PROG_CYC - 1);
                end
            end
            S_AUTOSEL:  if (wr_en && cmd_d == C_RESET) d.st = S_READ;
            S_ERA_SET:  if (wr_en) d.st = (cadr_d == A_KEY1 && cmd_d == C_KEY1) ? S_ERA_UNL1 : S_READ;
            S_ERA_UNL1: if (wr_en) d.st = (cadr_d == A_KEY2 && cmd_d == C_KEY2) ? S_ERA_UNL2 : S_READ;
            S_ERA_UNL2: if (wr_en) begin
                if (cmd_d == C_SECT) begin
                    d.st           = S_ERA_WIN;
                    d.sel          = '0;
                    d.sel[sect_d]  = 1'b1;
                    d.pend         = '0;
                    d.pend[sect_d] = 1'b1;
                    d.cnt          = CNT_W'(ERASE_WIN - 1);
                end else begin
                    d.st = S_READ;
                end
            end
            S_PROG_BUSY: begin
                if (q.cnt == '0) begin
                    prog_en = 1'b1;
                    d.st    = S_READ;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            S_ERA_WIN: begin
                if (wr_en && cmd_d == C_SECT) begin
                    d.sel[sect_d]  = 1'b1;
                    d.pend[sect_d] = 1'b1;
                    d.cnt          = CNT_W'(ERASE_WIN - 1);
                end else if (q.cnt == '0) begin
                    d.st  = S_ERA_BUSY;
                    d.cnt = CNT_W'(ERASE_CYC - 1);
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            S_ERA_BUSY: begin
                if (q.cnt == '0) begin
                    erase_en = 1'b1;
                    d.pend   = pend_left;
                    if (pend_left == '0) begin
                        d.st  = S_READ;
                        d.sel = '0;
                    end else begin
                        d.cnt = CNT_W'(ERASE_CYC - 1);
                    end
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            S_FAIL: if (wr_en && cmd_d == C_RESET) d.st = S_READ;
            default: d.st = S_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_READ;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.rdata;
    assign ready = ~busy_d;

    // R10: the device becomes ready only by landing in array-read state
    p_ready_to_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> q.st == S_READ);

    // R8: the failure state persists until the reset command
    p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_FAIL && !(wr_en && wdata[7:0] == C_RESET)) |=> (q.st == S_FAIL && !ready));

    // R9: writes during a running erase do not change the operation
    p_erase_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_ERA_BUSY && wr_en) |=> q.st inside {S_ERA_BUSY, S_READ});

    // R3: a program commit never sees an empty target state transition
    p_prog_from_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> (ready && $past(q.st) == S_PROG_BUSY));

endmodule

// File: tb/nor_cmd_emu_tb.sv
module nor_cmd_emu_tb;
    localparam int PROG_CYC  = 5;
    localparam int ERASE_WIN = 4;
    localparam int ERASE_CYC = 12;
    localparam logic [15:0] MFR = 16'h00C2;
    localparam logic [15:0] DEV = 16'h22A7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [10:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ready;

    int vecs = 0;
    int errs = 0;
    logic [15:0] exp_mem [64];

    always #4 clk = ~clk;

    nor_cmd_emu #(.PROG_CYC(PROG_CYC), .ERASE_WIN(ERASE_WIN), .ERASE_CYC(ERASE_CYC),
                  .MFR_ID(MFR), .DEV_ID(DEV)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        vecs++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [15:0] dv);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = dv;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [15:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; v = rdata;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic prog_word(input logic [10:0] a, input logic [15:0] dv);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0); wr(a, dv);
    endtask

    task automatic erase_start(input logic [10:0] a);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(a, 16'h0030);
    endtask

    task automatic check_all(input string tag);
        logic [15:0] v;
        for (int i = 0; i < 64; i++) begin
            rd(11'(i), v);
            chk(tag, v, exp_mem[i]);
        end
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'(i * 4409) ^ 16'h5A3C;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [15:0] v, v2, nv;
        int n;
        for (int i = 0; i < 64; i++) exp_mem[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 ready", {15'd0, ready}, 16'd1);
        check_all("R1 erased array");

        // R2 / R12: identification, upper data bits ignored in command match
        wr(11'h555, 16'h12AA); wr(11'h2AA, 16'hFF55); wr(11'h555, 16'h3490);
        rd(11'h000, v); chk("R2 R12 mfr id", v, MFR);
        rd(11'h001, v); chk("R2 dev id", v, DEV);
        rd(11'h002, v); chk("R2 other offset", v, 16'h0000);
        wr(11'h555, 16'h00AA);
        rd(11'h000, v); chk("R2 non-reset write ignored", v, MFR);
        wr(11'h000, 16'h00F0);
        rd(11'h000, v); chk("R2 back to array", v, 16'hFFFF);

        // R3 / R10: program sweep with measured busy time
        for (int i = 0; i < 64; i++) begin
            prog_word(11'(i), pat(i));
            wait_ready(n);
            chk("R10 program busy cycles", 16'(n), 16'(PROG_CYC));
            exp_mem[i] = pat(i);
        end
        check_all("R3 program readback");

        // R4 / R6: status during program
        nv = exp_mem[5] & 16'hF0F0;
        prog_word(11'd5, nv);
        rd(11'd5, v); rd(11'd100, v2);
        chk("R4 dq7 complement", {15'd0, v[7]}, {15'd0, ~nv[7]});
        chk("R4 dq7 complement any addr", {15'd0, v2[7]}, {15'd0, ~nv[7]});
        chk("R6 dq6 toggles", {15'd0, v[6] ^ v2[6]}, 16'd1);
        chk("R6 no fail flag", {15'd0, v[5]}, 16'd0);
        wait_ready(n);
        exp_mem[5] = nv;
        rd(11'd5, v); rd(11'd5, v2);
        chk("R4 true data after", v, nv);
        chk("R6 stable after", v2, nv);

        // R8: raising a bit fails and sticks
        prog_word(11'd5, 16'hFFFF);
        rd(11'd5, v);
        chk("R8 dq5 set", {15'd0, v[5]}, 16'd1);
        chk("R8 ready low", {15'd0, ready}, 16'd0);
        repeat (20) @(negedge clk);
        wr(11'h555, 16'h00AA);
        rd(11'd5, v);
        chk("R8 dq5 still set", {15'd0, v[5]}, 16'd1);
        wr(11'h000, 16'h00F0);
        chk("R8 ready after reset cmd", {15'd0, ready}, 16'd1);
        rd(11'd5, v); chk("R8 array unchanged", v, nv);

        // R11: broken sequence starts nothing
        wr(11'h555, 16'h00AA); wr(11'h2AB, 16'h0055); wr(11'h555, 16'h00A0); wr(11'd3, 16'h0000);
        chk("R11 still ready", {15'd0, ready}, 16'd1);
        rd(11'd3, v); chk("R11 word unchanged", v, exp_mem[3]);

        // R5 / R7 / R9: two-sector erase
        erase_start(11'd16);
        wr(11'd48, 16'h0030);
        rd(11'd16, v);
        chk("R9 dq3 low in window", {15'd0, v[3]}, 16'd0);
        chk("R10 busy in window", {15'd0, ready}, 16'd0);
        repeat (4) @(negedge clk);
        rd(11'd16, v); rd(11'd17, v2);
        chk("R9 dq3 high when running", {15'd0, v[3]}, 16'd1);
        chk("R5 dq7 zero in erase", {15'd0, v[7]}, 16'd0);
        chk("R7 dq2 toggles in chosen sector", {15'd0, v[2] ^ v2[2]}, 16'd1);
        rd(11'd0, v); rd(11'd1, v2);
        chk("R7 dq2 steady outside", {15'd0, v[2] ^ v2[2]}, 16'd0);
        chk("R6 dq6 toggles in erase", {15'd0, v[6] ^ v2[6]}, 16'd1);
        wr(11'h000, 16'h00F0);
        rd(11'd16, v);
        chk("R9 write ignored while running", {15'd0, v[3]}, 16'd1);
        wait_ready(n);
        for (int i = 16; i < 32; i++) exp_mem[i] = 16'hFFFF;
        for (int i = 48; i < 64; i++) exp_mem[i] = 16'hFFFF;
        check_all("R5 R9 two sectors erased");

        // R10: single-sector erase timing
        erase_start(11'd40);
        wait_ready(n);
        chk("R10 erase busy cycles", 16'(n), 16'(ERASE_WIN + ERASE_CYC));
        for (int i = 32; i < 48; i++) exp_mem[i] = 16'hFFFF;
        check_all("R5 single sector erased");

        // R3: program again after erase
        prog_word(11'd20, 16'h1234);
        wait_ready(n);
        rd(11'd20, v); chk("R3 program after erase", v, 16'h1234);

        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule